// File: doc/BRIEF.md
# Host Byte Transfer Handshake Engine

This block moves bytes between a host processor and a peripheral controller over three active-low control lines in an 8-bit I/O port, plus one shared 8-bit shift-data register. When the host shifts data out, each toggle of the acknowledge or transfer-in-progress line copies the shift-data byte into an outbound packet buffer. When the host shifts data in, each toggle loads the next reply byte from an inbound buffer into the shift-data register. The block drives the request line to signal that a reply is waiting, and to signal that the reply is finished.

Each byte event schedules a shift-register interrupt. The interrupt arrives after a fixed delay, which is derived from the clock frequency, or at once when the port direction register reads all ones. When the transfer-in-progress line returns high, the captured bytes are handed to a packet consumer as one packet. The consumer reads them through a byte read port. A reply producer fills the inbound buffer through a write port and then commits it with a length.

Top module: `hs_xfer_engine`

## Requirements
- R1: Port bit 3 is the request line, bit 4 the acknowledge line and bit 5 the transfer-in-progress line, all active low. A port write stores the whole byte, and the block alters only bit 3. After reset the port reads 0x00, with no interrupt and no packet. The port value changes only on a port write, a control write or a reply commit.
- R2: Shift-out capture. When the transfer-in-progress line (bit 5) is low and the shift-out mode is on (`ctl_out_mode`=1), any change of bit 4 or bit 5 against the stored port value appends the shift-data byte to the outbound buffer and schedules an interrupt.
- R3: The outbound buffer holds DEPTH (16) bytes. A byte offered while it is full is dropped, and no interrupt is scheduled for it.
- R4: Shift-in loading. When bit 5 is low, the shift-out mode is off and reply bytes remain, any change of bit 4 or bit 5 loads the next reply byte into the shift-data register and schedules an interrupt. Loading the last reply byte drives bit 3 high.
- R5: Idle mirroring. When bit 5 is high in both the stored and the new port value and bit 4 changes, bit 3 takes the new bit 4 level and an interrupt is scheduled.
- R6: When bit 5 goes from low to high, an interrupt is always scheduled. If at least one byte was captured, a one-cycle `pkt_valid` is given with `pkt_len` equal to the byte count, and the outbound count returns to zero.
- R7: When bit 5 is high, bit 4 is unchanged and reply bytes remain unsent, bit 3 is driven low.
- R8: A scheduled interrupt appears as a one-cycle `sr_irq` pulse DELAY_CYC (= DELAY_US*CLK_KHZ/1000, 30 by default) cycles later than an immediate one. It is immediate (visible right after the scheduling edge) when `dir_b` is 0xFF. A new delayed schedule restarts the count.
- R9: A reply commit sets the reply length, restarts the reply index at zero, evaluates the handshake again with the current port value and schedules an interrupt.
- R10: An evaluation in which neither bit 4 nor bit 5 changes while bit 5 is low has no effect. The shift-data register keeps its value and no interrupt is scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_wr | input | 1 | Host write strobe for the control port |
| port_wdata | input | 8 | Port byte written by the host |
| ctl_wr | input | 1 | Host write strobe for the shift-direction control |
| ctl_out_mode | input | 1 | Shift-out mode (1 = host sends bytes) |
| dir_b | input | 8 | Port direction register value; 0xFF makes interrupts immediate |
| sr_wr | input | 1 | Host write strobe for the shift-data register |
| sr_wdata | input | 8 | Shift-data byte written by the host |
| rin_we | input | 1 | Reply buffer byte write strobe |
| rin_addr | input | $clog2(DEPTH) | Reply buffer write address |
| rin_data | input | 8 | Reply byte |
| rin_commit | input | 1 | Commit a new reply packet |
| rin_len | input | $clog2(DEPTH+1) | Length of the committed reply |
| pkt_addr | input | $clog2(DEPTH) | Outbound buffer read address |
| port_q | output | 8 | Current port value including the driven request bit |
| sr_rdata | output | 8 | Shift-data register |
| sr_irq | output | 1 | Shift-register interrupt pulse |
| pkt_valid | output | 1 | One-cycle pulse: a captured packet is ready |
| pkt_len | output | $clog2(DEPTH+1) | Byte count of the delivered packet |
| pkt_byte | output | 8 | Outbound buffer byte at `pkt_addr` |

## Verification
The port value, shift-data register, `pkt_valid` and an immediate `sr_irq` all register on the clock edge that takes the strobe. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, which is the first point where these results are visible. A delayed interrupt lands DELAY_CYC edges after that point. The bench counts falling edges and checks that the pulse is absent one sample earlier and present at the due sample. Delivered packets are compared by a scoreboard monitor against a queue of expected packets. The monitor reads the bytes at the same falling edge as `pkt_valid`, before the next edge can change the buffer.

// File: rtl/hsx_pkg.sv
// Shared constants for the host byte transfer handshake engine.
// Assumes an 8-bit control port with the three handshake lines at fixed bits.
package hsx_pkg;
    localparam int BIT_REQ = 3;   // request line, driven by the block
    localparam int BIT_ACK = 4;   // acknowledge line, driven by the host
    localparam int BIT_TIP = 5;   // transfer in progress, driven by the host
endpackage

// File: rtl/hsx_outbuf.sv
// Outbound packet buffer: collects bytes shifted out by the host and
// hands them over as one packet. Assumes deliver and cap never coincide.
module hsx_outbuf #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap,
    input  logic [7:0]                   din,
    input  logic                         deliver,
    input  logic [$clog2(DEPTH)-1:0]     rd_addr,
    output logic                         full,
    output logic                         pkt_valid,
    output logic [$clog2(DEPTH+1)-1:0]   pkt_len,
    output logic [7:0]                   rd_byte
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] idx;

    assign full    = (idx == LW'(DEPTH));
    assign rd_byte = mem[rd_addr];

    // Store an accepted byte at the current index.
    always_ff @(posedge clk) begin
        if (cap && !full) mem[idx[AW-1:0]] <= din;
    end

    // Advance the index on capture, clear it and publish the count on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            pkt_valid <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if (deliver) begin
                if (idx != '0) begin
                    pkt_valid <= 1'b1;
                    pkt_len   <= idx;
                end
                idx <= '0;
            end else if (cap && !full) begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hsx_inbuf.sv
// Inbound reply buffer: holds a reply packet and presents the next byte.
// The status outputs already reflect a commit in the same cycle, so the
// handshake can be evaluated against the freshly restarted index.
module hsx_inbuf #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(DEPTH)-1:0]     waddr,
    input  logic [7:0]                   wdata,
    input  logic                         commit,
    input  logic [$clog2(DEPTH+1)-1:0]   clen,
    input  logic                         pop,
    output logic [7:0]                   cur_byte,
    output logic                         pending,
    output logic                         last
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] idx, size;
    logic [LW-1:0] idx_eff, size_eff;

    // Effective index and length, taking a same-cycle commit into account.
    always_comb begin
        idx_eff  = commit ? '0 : idx;
        size_eff = size;
        if (commit) size_eff = (clen > LW'(DEPTH)) ? LW'(DEPTH) : clen;
    end

    assign pending  = (idx_eff < size_eff);
    assign last     = (({1'b0, idx_eff} + 1'b1) >= {1'b0, size_eff});
    assign cur_byte = mem[idx_eff[AW-1:0]];

    // Reply byte storage written by the reply producer.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Track the reply length and the next byte to hand out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            size <= '0;
        end else begin
            size <= size_eff;
            if (pop)         idx <= idx_eff + 1'b1;
            else if (commit) idx <= '0;
        end
    end
endmodule

// File: rtl/hsx_irq_delay.sv
// Interrupt delay: turns a schedule request into a one-cycle pulse,
// either at once or DELAY_CYC cycles later. A delayed request replaces
// any pending one; an immediate request leaves a pending count alone.
module hsx_irq_delay #(
    parameter int DELAY_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sched,
    input  logic immediate,
    output logic irq
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] cnt;
    logic          arm;

    assign arm = sched && !immediate;

    // Count down a delayed request and pulse when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= (sched && immediate) || (cnt == CW'(1) && !arm);
            if (arm)             cnt <= CW'(DELAY_CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hs_xfer_engine.sv
// Host byte transfer handshake engine. It evaluates the three-line
// handshake on every port write, control write and reply commit, moves one
// byte per line toggle, drives the request line and schedules the
// shift-register interrupt. Assumes at most one byte event per cycle.
// The stored port value doubles as the previous value for edge detection.
module hs_xfer_engine #(
    parameter int DEPTH    = 16,
    parameter int CLK_KHZ  = 100,
    parameter int DELAY_US = 300
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         port_wr,
    input  logic [7:0]                   port_wdata,
    input  logic                         ctl_wr,
    input  logic                         ctl_out_mode,
    input  logic [7:0]                   dir_b,
    input  logic                         sr_wr,
    input  logic [7:0]                   sr_wdata,
    input  logic                         rin_we,
    input  logic [$clog2(DEPTH)-1:0]     rin_addr,
    input  logic [7:0]                   rin_data,
    input  logic                         rin_commit,
    input  logic [$clog2(DEPTH+1)-1:0]   rin_len,
    input  logic [$clog2(DEPTH)-1:0]     pkt_addr,
    output logic [7:0]                   port_q,
    output logic [7:0]                   sr_rdata,
    output logic                         sr_irq,
    output logic                         pkt_valid,
    output logic [$clog2(DEPTH+1)-1:0]   pkt_len,
    output logic [7:0]                   pkt_byte
);
    import hsx_pkg::*;

    localparam int DELAY_CYC = (DELAY_US * CLK_KHZ) / 1000;

    logic [7:0] prev_port, port_cand, port_next, sr_q;
    logic       mode_q, mode_cand, do_eval, line_chg;
    logic       cap, pop, deliver, sched;
    logic       out_full, in_pending, in_last;
    logic [7:0] in_byte;

    assign do_eval   = port_wr || ctl_wr || rin_commit;
    assign port_cand = port_wr ? port_wdata : prev_port;
    assign mode_cand = ctl_wr ? ctl_out_mode : mode_q;
    assign line_chg  = (port_cand[BIT_ACK] != prev_port[BIT_ACK]) ||
                       (port_cand[BIT_TIP] != prev_port[BIT_TIP]);

    // Handshake evaluation: decide the byte action and the new request level.
    always_comb begin
        port_next = port_cand;
        cap       = 1'b0;
        pop       = 1'b0;
        deliver   = 1'b0;
        sched     = 1'b0;
        if (do_eval) begin
            if (!port_cand[BIT_TIP]) begin
                if (mode_cand) begin
                    if (line_chg) begin
                        cap   = 1'b1;
                        sched = !out_full;
                    end
                end else if (in_pending && line_chg) begin
                    pop   = 1'b1;
                    sched = 1'b1;
                    if (in_last) port_next[BIT_REQ] = 1'b1;
                end
            end else if (prev_port[BIT_TIP] &&
                         port_cand[BIT_ACK] != prev_port[BIT_ACK]) begin
                port_next[BIT_REQ] = port_cand[BIT_ACK];
                sched              = 1'b1;
            end else begin
                if (!prev_port[BIT_TIP]) begin
                    deliver = 1'b1;
                    sched   = 1'b1;
                end
                if (in_pending) port_next[BIT_REQ] = 1'b0;
            end
        end
    end

    // Port value, shift direction and shift-data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_port <= '0;
            mode_q    <= 1'b0;
            sr_q      <= '0;
        end else begin
            if (do_eval) prev_port <= port_next;
            mode_q <= mode_cand;
            if (pop)        sr_q <= in_byte;
            else if (sr_wr) sr_q <= sr_wdata;
        end
    end

    assign port_q   = prev_port;
    assign sr_rdata = sr_q;

    hsx_outbuf #(.DEPTH(DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n), .cap(cap), .din(sr_q), .deliver(deliver),
        .rd_addr(pkt_addr), .full(out_full), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len), .rd_byte(pkt_byte)
    );

    hsx_inbuf #(.DEPTH(DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .we(rin_we), .waddr(rin_addr),
        .wdata(rin_data), .commit(rin_commit), .clen(rin_len), .pop(pop),
        .cur_byte(in_byte), .pending(in_pending), .last(in_last)
    );

    hsx_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .sched(sched || rin_commit),
        .immediate(dir_b == 8'hFF), .irq(sr_irq)
    );
endmodule

// File: rtl/hsx_checker.sv
// Protocol checker for the handshake engine, attached through bind.
module hsx_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       port_wr,
    input logic                       ctl_wr,
    input logic                       rin_commit,
    input logic [7:0]                 port_q,
    input logic                       pkt_valid,
    input logic [$clog2(DEPTH+1)-1:0] pkt_len
);
    localparam int LW = $clog2(DEPTH+1);

    // R6: a delivered packet always carries at least one byte
    assert_pkt_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_len != '0);

    // R3: a packet never exceeds the buffer depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_len <= LW'(DEPTH));

    // R1: the port value only moves on an evaluation
    assert_port_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr || ctl_wr || rin_commit) |=> $stable(port_q));

    // R6: delivery only follows a host port write
    assert_pkt_after_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(port_wr));
endmodule

bind hs_xfer_engine hsx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .ctl_wr(ctl_wr),
    .rin_commit(rin_commit), .port_q(port_q), .pkt_valid(pkt_valid),
    .pkt_len(pkt_len)
);

// File: tb/hs_xfer_engine_test.sv
`timescale 1ns/1ps
module hs_xfer_engine_test;
    localparam real CLK_PERIOD = 10.0;
    localparam int  DEPTH = 16;
    localparam int  DLY   = 30;

    typedef struct { int len; logic [7:0] b [16]; } pkt_t;

    logic clk = 0, rst_n = 0;
    logic port_wr = 0, ctl_wr = 0, ctl_out_mode = 0, sr_wr = 0;
    logic rin_we = 0, rin_commit = 0;
    logic [7:0] port_wdata = 0, dir_b = 8'hFF, sr_wdata = 0, rin_data = 0;
    logic [3:0] rin_addr = 0, pkt_addr = 0;
    logic [4:0] rin_len = 0;
    logic [7:0] port_q, sr_rdata, pkt_byte;
    logic       sr_irq, pkt_valid;
    logic [4:0] pkt_len;

    int n_chk = 0, n_fail = 0;
    pkt_t exp_q [$];

    hs_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
        .ctl_wr(ctl_wr), .ctl_out_mode(ctl_out_mode), .dir_b(dir_b),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .rin_we(rin_we),
        .rin_addr(rin_addr), .rin_data(rin_data), .rin_commit(rin_commit),
        .rin_len(rin_len), .pkt_addr(pkt_addr), .port_q(port_q),
        .sr_rdata(sr_rdata), .sr_irq(sr_irq), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len), .pkt_byte(pkt_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // All tasks are entered and left at a falling edge.
    task automatic wr_port(input logic [7:0] v);
        port_wr = 1; port_wdata = v; @(negedge clk); port_wr = 0;
    endtask
    task automatic wr_ctl(input logic m);
        ctl_wr = 1; ctl_out_mode = m; @(negedge clk); ctl_wr = 0;
    endtask
    task automatic wr_sr(input logic [7:0] v);
        sr_wr = 1; sr_wdata = v; @(negedge clk); sr_wr = 0;
    endtask
    task automatic load_reply(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input int n);
        logic [7:0] bs [3];
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        for (int i = 0; i < n; i++) begin
            rin_we = 1; rin_addr = 4'(i); rin_data = bs[i]; @(negedge clk);
        end
        rin_we = 0;
        rin_commit = 1; rin_len = 5'(n); @(negedge clk); rin_commit = 0;
    endtask

    // Scoreboard monitor: compare each delivered packet with the queue front.
    always @(negedge clk) begin
        if (rst_n && pkt_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected packet", int'(pkt_len), 0);
            end else begin
                pkt_t e;
                e = exp_q.pop_front();
                chk_eq("R6 pkt_len", int'(pkt_len), e.len);
                for (int i = 0; i < e.len; i++) begin
                    pkt_addr = 4'(i);
                    #0.1;
                    chk_eq("R2 pkt byte", int'(pkt_byte), int'(e.b[i]));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        pkt_t p;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 reset port", int'(port_q), 0);
        chk_eq("R1 reset irq", int'(sr_irq), 0);
        chk_eq("R1 reset pkt", int'(pkt_valid), 0);

        // R10: shift-out mode with bit 5 already low and no line change
        wr_ctl(1);
        chk_eq("R10 no irq without change", int'(sr_irq), 0);
        // R6: bit 5 rising with nothing captured: irq, no packet
        wr_port(8'h38);
        chk_eq("R6 irq on rise", int'(sr_irq), 1);
        chk_eq("R1 port stored", int'(port_q), 8'h38);

        // R2: three-byte host packet
        p.len = 3; p.b[0] = 8'hA1; p.b[1] = 8'hB2; p.b[2] = 8'hC3;
        exp_q.push_back(p);
        wr_sr(8'hA1); wr_port(8'h10);
        chk_eq("R2 irq on capture", int'(sr_irq), 1);
        wr_sr(8'hB2); wr_port(8'h00);
        chk_eq("R2 irq on capture 2", int'(sr_irq), 1);
        wr_sr(8'hC3); wr_port(8'h10);
        wr_port(8'h38);
        chk_eq("R6 irq at end of packet", int'(sr_irq), 1);
        repeat (2) @(negedge clk);

        // R3: 18 bytes offered, the last two dropped
        p.len = 16;
        for (int k = 0; k < 16; k++) p.b[k] = 8'(8'h40 + k);
        exp_q.push_back(p);
        for (int k = 0; k < 18; k++) begin
            wr_sr(8'(8'h40 + k));
            wr_port((k % 2 == 0) ? 8'h10 : 8'h00);
            if (k >= 16) chk_eq("R3 no irq when full", int'(sr_irq), 0);
            else if (k == 15) chk_eq("R3 irq on last fit", int'(sr_irq), 1);
        end
        wr_port(8'h38);
        repeat (2) @(negedge clk);

        // R9/R7: reply commit while idle drives request low and interrupts
        wr_ctl(0);
        load_reply(8'h11, 8'h22, 8'h33, 3);
        chk_eq("R9 irq on commit", int'(sr_irq), 1);
        chk_eq("R7 request low when pending", int'(port_q), 8'h30);

        // R4: shift-in of the reply
        wr_port(8'h10);
        chk_eq("R4 first reply byte", int'(sr_rdata), 8'h11);
        chk_eq("R4 irq on load", int'(sr_irq), 1);
        // R10: control write, no line change, bit 5 low
        wr_ctl(0);
        chk_eq("R10 sr unchanged", int'(sr_rdata), 8'h11);
        chk_eq("R10 no irq", int'(sr_irq), 0);
        wr_port(8'h00);
        chk_eq("R4 second reply byte", int'(sr_rdata), 8'h22);
        wr_port(8'h10);
        chk_eq("R4 last reply byte", int'(sr_rdata), 8'h33);
        chk_eq("R4 request high after last", int'(port_q), 8'h18);
        wr_port(8'h38);
        chk_eq("R6 irq on rise without packet", int'(sr_irq), 1);
        chk_eq("R7 no pending keeps request", int'(port_q), 8'h38);

        // R5: idle mirroring of acknowledge onto request
        wr_port(8'h28);
        chk_eq("R5 request follows ack low", int'(port_q), 8'h20);
        chk_eq("R5 irq on mirror", int'(sr_irq), 1);
        wr_port(8'h38);
        chk_eq("R5 request follows ack high", int'(port_q), 8'h38);

        // R9: new reply restarts at index zero
        load_reply(8'h55, 8'h66, 8'h00, 2);
        wr_port(8'h10);
        chk_eq("R9 index restarted", int'(sr_rdata), 8'h55);
        wr_port(8'h00);
        chk_eq("R9 second byte", int'(sr_rdata), 8'h66);
        wr_port(8'h38);
        @(negedge clk);

        // R8: delayed interrupt when the direction register is not all ones
        dir_b = 8'h00;
        @(negedge clk);
        wr_port(8'h28);
        chk_eq("R8 no immediate irq", int'(sr_irq), 0);
        for (int k = 1; k <= DLY; k++) begin
            @(negedge clk);
            if (k == DLY - 1) chk_eq("R8 not early", int'(sr_irq), 0);
            if (k == DLY)     chk_eq("R8 irq at delay", int'(sr_irq), 1);
        end
        @(negedge clk);
        chk_eq("R8 single pulse", int'(sr_irq), 0);

        repeat (3) @(negedge clk);
        chk_eq("R6 all packets seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule